// File: doc/BRIEF.md
# SPI Target with Packed Word FIFOs

This block is the target side of an SPI link. An external controller drives the serial clock, the chip-select and the controller-to-target data line. The block answers on the target-to-controller line. The host side uses a small 32-bit register bus. Software writes a configuration byte, loads outgoing words into a transmit queue, and pulls incoming words out of a receive queue after the transaction ends.

The serial inputs are brought into the system clock domain through two-flop synchronizers, so every serial edge is seen as a system-clock event. Bytes travel from the low byte lane of each 32-bit word upward. Each direction has its own bit order and its own optional byte-lane reversal.

A transaction ends when chip-select goes high. At that point any partly filled receive word is flushed and a one-cycle done pulse is raised. A soft-reset write empties both queues and clears the partial shift state between transfers.

Top module: `spi_word_target`

## Requirements
- R1: After reset the configuration reads back as 0, `spi_miso` is 1 and `data_done` is low.
- R2: Offset 0x0 holds the configuration byte and reads back as written in bits 7:0, with bits 31:8 reading 0. The fields are:
  - bit 0: receive enable
  - bit 1: transmit enable
  - bit 2: clock polarity
  - bit 3: clock phase
  - bit 4: receive MSB-first
  - bit 5: transmit MSB-first
  - bit 6: receive byte-lane reversal
  - bit 7: transmit byte-lane reversal
- R3: A write to offset 0x4 queues one transmit word. Its bytes are sent from bits 7:0 upward. Within each byte the bits go MSB first when bit 5 is 1 and LSB first when it is 0.
- R4: A read of offset 0x8 returns and removes the oldest received word. The first byte received lands in bits 7:0. Within each byte, bit 4 selects MSB-first (1) or LSB-first (0). A read while the queue is empty returns 0.
- R5: When chip-select rises with a word partly filled, that word is queued with its bytes in the low lanes and zeros above.
- R6: All four clock modes work. With phase 0, data is sampled on the leading clock edge and changed on the trailing edge. With phase 1, it is the other way round. The polarity bit gives the idle clock level.
- R7: When the transmit queue runs dry during a transaction, zero bytes are sent.
- R8: With transmit disabled, or with chip-select high, `spi_miso` stays at 1.
- R9: With receive disabled, nothing is written to the receive queue.
- R10: Writing 1 to bit 0 of offset 0xC empties both queues and clears the partial shift state.
- R11: Each rising edge of chip-select gives exactly one single-cycle `data_done` pulse.
- R12: With bit 7 set, each transmit word is byte-reversed before it is sent. With bit 6 set, each received word is byte-reversed before it is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the receive queue at offset 0x8 |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| spi_sclk | input | 1 | Serial clock from the controller |
| spi_mosi | input | 1 | Controller-to-target data |
| spi_cs_n | input | 1 | Active-low chip-select |
| spi_miso | output | 1 | Target-to-controller data |
| data_done | output | 1 | Single-cycle pulse after chip-select deasserts |

## Verification
The bench runs all four clock modes and mixes the bit orders, so a block that samples on the wrong edge or ignores one direction's order returns shifted or mirrored bytes. Transfers of 6 and 7 bytes target the partial-word flush; a design that dropped or misplaced the tail would lose bytes or leave them in the high lanes. Further runs cover transmit underrun, each direction disabled, byte-lane reversal, and soft reset with data pending. A queue that survives the reset would replay stale words, and a disabled direction that leaks would send data instead of idle ones or fill the receive queue.

// File: rtl/spi_word_target_pkg.sv
package spi_word_target_pkg;

    localparam int WORD_W = 32;

    typedef struct packed {
        logic tx_swap;
        logic rx_swap;
        logic tx_msb;
        logic rx_msb;
        logic cpha;
        logic cpol;
        logic tx_en;
        logic rx_en;
    } cfg_t;

    localparam logic [3:0] ADDR_CFG = 4'h0;
    localparam logic [3:0] ADDR_TXD = 4'h4;
    localparam logic [3:0] ADDR_RXD = 4'h8;
    localparam logic [3:0] ADDR_RST = 4'hC;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // Position of the k-th serial bit inside its byte
    function automatic logic [2:0] bit_sel(input logic msb_first, input logic [2:0] k);
        return msb_first ? ~k : k;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int           N    = 3,
    parameter logic [N-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= INIT;
            q      <= INIT;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [AW:0]      level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr, rd_ptr;

    assign level = wr_ptr - rd_ptr;
    assign empty = (level == '0);
    assign full  = (level == (AW+1)'(DEPTH));
    assign dout  = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr[AW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) wr_ptr <= wr_ptr + 1'b1;
            if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_word_target_pkg::*;
#(
    parameter logic MISO_IDLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  cfg_t              cfg,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              cs_s,
    input  logic [WORD_W-1:0] tx_in,
    input  logic              tx_empty,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              miso,
    output logic              done
);
    localparam int CW = $clog2(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    logic              sclk_d, cs_d;
    logic [WORD_W-1:0] tx_word, rx_acc, rx_next, load_word;
    logic [CW-1:0]     tx_idx, rx_cnt;
    logic              tx_skip;

    wire active    = !cs_s;
    wire cs_fall   = cs_d && !cs_s;
    wire cs_rise   = !cs_d && cs_s;
    wire rise      = !sclk_d && sclk_s;
    wire fall      = sclk_d && !sclk_s;
    wire sample_e  = (cfg.cpol ^ cfg.cpha) ? fall : rise;
    wire launch_e  = (cfg.cpol ^ cfg.cpha) ? rise : fall;
    wire [CW-1:0] tx_pos = {tx_idx[CW-1:3], bit_sel(cfg.tx_msb, tx_idx[2:0])};
    wire [CW-1:0] rx_pos = {rx_cnt[CW-1:3], bit_sel(cfg.rx_msb, rx_cnt[2:0])};

    always_comb begin
        load_word = '0;
        if (cfg.tx_en && !tx_empty)
            load_word = cfg.tx_swap ? swap_bytes(tx_in) : tx_in;
        rx_next         = rx_acc;
        rx_next[rx_pos] = mosi_s;
    end

    assign tx_pop = cfg.tx_en && !tx_empty &&
                    (cs_fall || (launch_e && active && !tx_skip && tx_idx == LAST));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sclk_d  <= 1'b0;
            cs_d    <= 1'b1;
            done    <= 1'b0;
            miso    <= MISO_IDLE;
            tx_word <= '0;
            tx_idx  <= '0;
            tx_skip <= 1'b0;
            rx_acc  <= '0;
            rx_cnt  <= '0;
            rx_push <= 1'b0;
            rx_word <= '0;
        end else begin
            sclk_d  <= sclk_s;
            cs_d    <= cs_s;
            done    <= cs_rise;
            rx_push <= 1'b0;
            miso    <= (cfg.tx_en && active) ? tx_word[tx_pos] : MISO_IDLE;

            // transmit side
            if (cs_fall) begin
                tx_idx  <= '0;
                tx_skip <= cfg.cpha;
                tx_word <= load_word;
            end else if (launch_e && active && cfg.tx_en) begin
                if (tx_skip) begin
                    tx_skip <= 1'b0;
                end else begin
                    tx_idx <= tx_idx + 1'b1;
                    if (tx_idx == LAST) tx_word <= load_word;
                end
            end

            // receive side
            if (cs_fall) begin
                rx_cnt <= '0;
                rx_acc <= '0;
            end else if (cs_rise) begin
                if (rx_cnt != '0 && cfg.rx_en) begin
                    rx_push <= 1'b1;
                    rx_word <= cfg.rx_swap ? swap_bytes(rx_acc) : rx_acc;
                end
                rx_cnt <= '0;
                rx_acc <= '0;
            end else if (sample_e && active && cfg.rx_en) begin
                if (rx_cnt == LAST) begin
                    rx_push <= 1'b1;
                    rx_word <= cfg.rx_swap ? swap_bytes(rx_next) : rx_next;
                    rx_acc  <= '0;
                    rx_cnt  <= '0;
                end else begin
                    rx_acc <= rx_next;
                    rx_cnt <= rx_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_word_target.sv
module spi_word_target
    import spi_word_target_pkg::*;
#(
    parameter int   FIFO_BYTES = 512,
    parameter logic MISO_IDLE  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        spi_sclk,
    input  logic        spi_mosi,
    input  logic        spi_cs_n,
    output logic        spi_miso,
    output logic        data_done
);
    localparam int FIFO_WORDS = FIFO_BYTES / (WORD_W / 8);
    localparam int LVL_W      = $clog2(FIFO_WORDS) + 1;

    cfg_t              cfg_q;
    logic [2:0]        sync_q;
    logic              tx_full, tx_empty, tx_pop, rx_full, rx_empty, rx_push;
    logic [WORD_W-1:0] tx_dout, rx_dout, rx_word;
    logic [LVL_W-1:0]  tx_level, rx_level;

    wire soft_rst = bus_wr && bus_addr == ADDR_RST && bus_wdata[0];
    wire tx_wr    = bus_wr && bus_addr == ADDR_TXD;
    wire rx_pop   = bus_rd && bus_addr == ADDR_RXD;

    always_ff @(posedge clk) begin
        if (rst)                                cfg_q <= '0;
        else if (bus_wr && bus_addr == ADDR_CFG) cfg_q <= cfg_t'(bus_wdata[7:0]);
    end

    always_comb begin
        case (bus_addr)
            ADDR_CFG: bus_rdata = {24'b0, cfg_q};
            ADDR_RXD: bus_rdata = rx_empty ? '0 : rx_dout;
            default:  bus_rdata = '0;
        endcase
    end

    spi_in_sync #(.N(3), .INIT(3'b100)) u_sync (
        .clk(clk), .rst(rst),
        .d({spi_cs_n, spi_mosi, spi_sclk}),
        .q(sync_q)
    );

    spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_WORDS)) u_tx_fifo (
        .clk(clk), .rst(rst), .clr(soft_rst),
        .push(tx_wr), .din(bus_wdata),
        .pop(tx_pop), .dout(tx_dout),
        .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_WORDS)) u_rx_fifo (
        .clk(clk), .rst(rst), .clr(soft_rst),
        .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_dout),
        .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    spi_shift_engine #(.MISO_IDLE(MISO_IDLE)) u_engine (
        .clk(clk), .rst(rst), .clr(soft_rst), .cfg(cfg_q),
        .sclk_s(sync_q[0]), .mosi_s(sync_q[1]), .cs_s(sync_q[2]),
        .tx_in(tx_dout), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word),
        .miso(spi_miso), .done(data_done)
    );
endmodule

// File: rtl/spi_word_target_chk.sv
module spi_word_target_chk #(
    parameter int DEPTH_W = 128,
    parameter int LW      = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          swrst,
    input logic          tx_en,
    input logic          miso,
    input logic          done,
    input logic          tx_full,
    input logic          rx_full,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level
);
    // R11: the done pulse lasts one cycle
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: transmit disabled holds the line at idle
    a_r8_tx_off_idle: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> miso == 1'b1);

    // R10: soft reset empties both queues
    a_r10_soft_clear: assert property (@(posedge clk) disable iff (rst)
        swrst |=> (tx_level == '0 && rx_level == '0));

    // R4: receive queue never exceeds its depth
    a_r4_rx_bound: assert property (@(posedge clk) disable iff (rst)
        (rx_level <= LW'(DEPTH_W)) && (rx_full == (rx_level == LW'(DEPTH_W))));

    // R3: transmit queue never exceeds its depth
    a_r3_tx_bound: assert property (@(posedge clk) disable iff (rst)
        (tx_level <= LW'(DEPTH_W)) && (tx_full == (tx_level == LW'(DEPTH_W))));
endmodule

bind spi_word_target spi_word_target_chk #(.DEPTH_W(FIFO_WORDS), .LW(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .swrst(soft_rst), .tx_en(cfg_q.tx_en),
    .miso(spi_miso), .done(data_done),
    .tx_full(tx_full), .rx_full(rx_full),
    .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/spi_word_target_bench.sv
module spi_word_target_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H = 8;

    logic        clk = 1'b0, rst = 1'b1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        spi_sclk = 0, spi_mosi = 0, spi_cs_n = 1, spi_miso, data_done;

    spi_word_target u_spi_word_target (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .spi_miso(spi_miso), .data_done(data_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, done_cnt = 0;
    logic [31:0] exp_rx_q[$];
    logic [7:0]  exp_tx_q[$];
    logic [7:0]  mosi_b[16];
    logic [7:0]  miso_b[16];
    logic [31:0] tx_w[4];

    always @(negedge clk) if (data_done) done_cnt++;

    function automatic logic [31:0] swp(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Controller model: mosi order follows rx setting, miso order follows tx setting
    task automatic spi_run(input int n, input bit cpol, input bit cpha,
                           input bit mosi_msb, input bit miso_msb);
        for (int j = 0; j < n; j++) miso_b[j] = 0;
        @(negedge clk);
        spi_sclk = cpol;
        if (!cpha) spi_mosi = mosi_b[0][mosi_msb ? 7 : 0];
        spi_cs_n = 0;
        waitn(H);
        for (int i = 0; i < n*8; i++) begin
            int bt = i / 8;
            int k  = i % 8;
            if (cpha) begin
                spi_sclk = ~cpol;
                spi_mosi = mosi_b[bt][mosi_msb ? 7-k : k];
                waitn(H);
                spi_sclk = cpol;
                miso_b[bt][miso_msb ? 7-k : k] = spi_miso;
                waitn(H);
            end else begin
                spi_sclk = ~cpol;
                miso_b[bt][miso_msb ? 7-k : k] = spi_miso;
                waitn(H);
                spi_sclk = cpol;
                if (i + 1 < n*8)
                    spi_mosi = mosi_b[(i+1)/8][mosi_msb ? 7-((i+1)%8) : (i+1)%8];
                waitn(H);
            end
        end
        spi_cs_n = 1;
        waitn(4*H);
    endtask

    task automatic do_xfer(input string req, input bit cpol, input bit cpha,
                           input bit rxm, input bit txm, input bit rxs, input bit txs,
                           input bit rx_en, input bit tx_en, input int n, input int ntx);
        logic [31:0] r;
        int d0;
        bus_write(4'h0, {24'b0, txs, rxs, txm, rxm, cpha, cpol, tx_en, rx_en});
        bus_write(4'hC, 32'h1);
        for (int w = 0; w < ntx; w++) bus_write(4'h4, tx_w[w]);
        for (int j = 0; j < n; j++) begin
            logic [31:0] w;
            if (!tx_en)          exp_tx_q.push_back(8'hFF);
            else if (j/4 < ntx) begin
                w = txs ? swp(tx_w[j/4]) : tx_w[j/4];
                exp_tx_q.push_back(w[8*(j%4) +: 8]);
            end else             exp_tx_q.push_back(8'h00);
        end
        if (rx_en) begin
            for (int w = 0; w < (n+3)/4; w++) begin
                logic [31:0] word = 0;
                for (int b = 0; b < 4; b++)
                    if (4*w + b < n) word[8*b +: 8] = mosi_b[4*w + b];
                exp_rx_q.push_back(rxs ? swp(word) : word);
            end
        end
        d0 = done_cnt;
        spi_run(n, cpol, cpha, rxm, txm);
        for (int j = 0; j < n; j++) check({req, " miso byte"}, 32'(miso_b[j]), 32'(exp_tx_q.pop_front()));
        while (exp_rx_q.size() > 0) begin
            bus_read(4'h8, r);
            check({req, " rx word"}, r, exp_rx_q.pop_front());
        end
        bus_read(4'h8, r);
        check("R4 empty read returns 0", r, 0);
        check("R11 one done pulse", 32'(done_cnt - d0), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        waitn(3);
        rst = 0;
        waitn(2);
        bus_read(4'h0, r);
        check("R1 cfg after reset", r, 0);
        check("R1 miso idle after reset", 32'(spi_miso), 1);
        check("R1 no done after reset", 32'(done_cnt), 0);

        bus_write(4'h0, 32'hFFFF_FF5A);
        bus_read(4'h0, r);
        check("R2 cfg readback", r, 32'h5A);

        tx_w[0] = 32'hA1B2C3D4; tx_w[1] = 32'h0F1E2D3C;
        for (int j = 0; j < 16; j++) mosi_b[j] = 8'(8'h35 * j + 8'h1B);
        do_xfer("R3 R6 mode0 msb", 0, 0, 1, 1, 0, 0, 1, 1, 8, 2);

        for (int j = 0; j < 16; j++) mosi_b[j] = 8'(8'h61 ^ (j * 8'h17));
        do_xfer("R5 R6 mode3 lsb", 1, 1, 0, 0, 0, 0, 1, 1, 6, 2);

        tx_w[0] = 32'h80402010; tx_w[1] = 32'h01020304;
        do_xfer("R5 R6 mode1 mixed", 0, 1, 0, 1, 0, 0, 1, 1, 7, 2);
        do_xfer("R6 mode2 mixed", 1, 0, 1, 0, 0, 0, 1, 1, 4, 1);

        do_xfer("R7 underrun", 0, 0, 1, 1, 0, 0, 1, 1, 8, 1);
        do_xfer("R8 tx disabled", 0, 0, 1, 1, 0, 0, 1, 0, 4, 1);
        do_xfer("R9 rx disabled", 1, 1, 1, 1, 0, 0, 0, 1, 4, 1);

        tx_w[0] = 32'h11223344; tx_w[1] = 32'hCAFEF00D;
        do_xfer("R12 lane reversal", 0, 0, 1, 1, 1, 1, 1, 1, 8, 2);

        // R10: soft reset discards pending words in both queues
        bus_write(4'h0, 32'h33);
        bus_write(4'hC, 32'h1);
        bus_write(4'h4, 32'hDEADBEEF);
        for (int j = 0; j < 4; j++) mosi_b[j] = 8'(8'h90 + j);
        spi_run(4, 0, 0, 1, 1);
        bus_write(4'hC, 32'h1);
        bus_read(4'h8, r);
        check("R10 rx queue cleared", r, 0);
        bus_write(4'h4, 32'h55AA55AA);
        bus_write(4'hC, 32'h1);
        spi_run(4, 0, 0, 1, 1);
        for (int j = 0; j < 4; j++) check("R10 tx queue cleared", 32'(miso_b[j]), 0);
        bus_read(4'h8, r);
        check("R10 rx works after clear", r, 32'h93929190);

        finish_run();
    end
endmodule